// File: doc/BRIEF.md
# Three-Wire Serial Shift Controller (Master/Slave)

This block moves 8-bit or 16-bit words over a three-wire synchronous serial link: two data lines and a shift clock, plus slave-select lines. One shift engine serves both roles. As master it makes the shift clock from the system clock through a programmable divider, drives the master-output data line and up to two select outputs, and samples the master-input line. As slave it follows an external shift clock and a select input. It drives the slave-output line only while selected, and it can echo the received bits back instead of sending its own word.

Software uses a four-word register port. One word holds configuration: role, length, clock-edge mode, idle clock level, echo, select polarity, select enables and interrupt enables. One word holds data: a write supplies the word to send, a read returns the receive buffer. One word holds status, and one holds the divider. Busy, buffer-full and overrun flags each have an enable and feed one interrupt line.

Top module: `mwspi_ctrl`

## Requirements
- R1: After reset, status reads 0, the interrupt is low, the shift clock output is low, both select outputs are high (select polarity defaults to active low), and the slave-output line is not driven.
- R2: Data goes out most-significant bit first. Configuration bit 1 selects 16-bit transfers (1) or 8-bit transfers (0). An 8-bit word uses data bits 7:0, and its received value reads back with bits 15:8 zero.
- R3: With configuration bit 2 at 0 (normal), output data changes on the rising shift-clock edge and input is sampled on the falling edge. With it at 1 (alternate), the edges swap.
- R4: While no transfer runs, the master shift clock sits at the level of configuration bit 3. A master transfer makes exactly twice as many clock edges as it has bits.
- R5: In master mode each shift-clock half period lasts DIV+1 system clocks, where DIV is register word 3.
- R6: During a master transfer, select output 0 (enable: configuration bit 6) and select output 1 (enable: bit 7) are active. Outside a transfer they are inactive. Configuration bit 5 set means active high, clear means active low.
- R7: In slave mode (configuration bit 0 clear) the controller shifts on the external clock only while select input 0 is at its active level. It drives the slave-output line only then, and the last sample completes the transfer.
- R8: With configuration bit 4 set in slave mode, each drive edge puts the most recently sampled input bit on the slave-output line.
- R9: A completed transfer sets buffer-full (status bit 1) and loads the buffer. Reading data word 1 clears buffer-full. Status bit 0 shows busy.
- R10: A transfer that completes while buffer-full is set sets overrun (status bit 2) and leaves the buffer unchanged. Overrun stays set until status bit 2 is written with 1.
- R11: A data-word write while busy is ignored. The word held for the next transfer stays unchanged.
- R12: The interrupt is the OR of busy, buffer-full and overrun, each masked by its enable (configuration bits 8, 9 and 10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| irq | output | 1 | Combined interrupt |
| sclk_i | input | 1 | Shift clock from external master |
| sclk_o | output | 1 | Shift clock in master mode |
| sclk_oe | output | 1 | Shift clock output enable |
| lna_i | input | 1 | Master-input / slave-output line, input side |
| lna_o | output | 1 | Master-input / slave-output line, output side |
| lna_oe | output | 1 | Enable for lna_o |
| lnb_i | input | 1 | Master-output / slave-input line, input side |
| lnb_o | output | 1 | Master-output / slave-input line, output side |
| lnb_oe | output | 1 | Enable for lnb_o |
| sel0_i | input | 1 | Select input in slave mode |
| sel0_o | output | 1 | Select output 0 in master mode |
| sel0_oe | output | 1 | Enable for sel0_o |
| sel1_o | output | 1 | Select output 1 (master only) |
| sel1_oe | output | 1 | Enable for sel1_o |

## Verification
If the engine's bit counter or edge decode goes wrong, the serial output shows it within one half period. The captured word is off by a bit, the master makes the wrong number of clock edges, or busy stays up so the status poll never clears. A wrong flag state appears on the interrupt pin in the cycle after the event. A wrong buffer or holding-register state appears at the next data read or the next slave transfer. The checks compare each word bit by bit on the line at the sample edge that the selected mode defines.

// File: rtl/mwspi_pkg.sv
package mwspi_pkg;

   // configuration word, bit 0 is role select
   typedef struct packed {
      logic ie_ovr;    // 10
      logic ie_full;   // 9
      logic ie_busy;   // 8
      logic sel1_en;   // 7
      logic sel0_en;   // 6
      logic sel_pol;   // 5  1 = active high
      logic echo;      // 4
      logic idle_hi;   // 3
      logic alt;       // 2
      logic long_x;    // 1
      logic master;    // 0
   } cfg_t;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_DATA = 2'd1;
   localparam logic [1:0] A_STAT = 2'd2;
   localparam logic [1:0] A_DIV  = 2'd3;

endpackage

// File: rtl/mwspi_sync.sv
module mwspi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) ff <= RST_VAL;
            else        ff <= d;
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) ff <= {STAGES{RST_VAL}};
            else        ff <= {ff[STAGES-2:0], d};
      end
   endgenerate

   assign q = ff[STAGES-1];
endmodule

// File: rtl/mwspi_clkgen.sv
module mwspi_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             idle_hi,
   input  logic [DIV_W-1:0] div,
   output logic             sclk,
   output logic             tick_rise,
   output logic             tick_fall
);
   logic [DIV_W-1:0] cnt;
   logic             lvl;
   logic             wrap;

   assign wrap = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         lvl <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         lvl <= idle_hi;
      end else if (wrap) begin
         cnt <= '0;
         lvl <= ~lvl;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign sclk      = lvl;
   assign tick_rise = wrap & ~lvl;
   assign tick_fall = wrap &  lvl;
endmodule

// File: rtl/mwspi_shifter.sv
module mwspi_shifter #(
   parameter int LONG_LEN  = 16,
   parameter int SHORT_LEN = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                master,
   input  logic                long_x,
   input  logic                alt,
   input  logic                idle_hi,
   input  logic                echo,
   input  logic                start,
   input  logic                slv_sel,
   input  logic                rise,
   input  logic                fall,
   input  logic                din,
   input  logic [LONG_LEN-1:0] tx_word,
   output logic                active,
   output logic                dout,
   output logic                done,
   output logic [LONG_LEN-1:0] rx_word
);
   localparam int CW = $clog2(2*LONG_LEN+1);

   logic [LONG_LEN-1:0] tx_sh, rx_sh, ld;
   logic [CW-1:0]       ecnt, scnt, ecnt_n, scnt_n, nbits;
   logic                sel_d, go, drv, smp, first_samp, fin;

   assign first_samp = alt ^ idle_hi;
   assign nbits  = long_x ? CW'(LONG_LEN) : CW'(SHORT_LEN);
   assign ld     = long_x ? tx_word : (tx_word << (LONG_LEN-SHORT_LEN));
   assign go     = master ? start : (slv_sel & ~sel_d & ~active);
   assign drv    = active & (alt ? fall : rise);
   assign smp    = active & (alt ? rise : fall);
   assign ecnt_n = ecnt + 1'b1;
   assign scnt_n = scnt + 1'b1;
   assign fin    = master ? ((drv | smp) && (ecnt_n == (nbits << 1)))
                          : (smp && (scnt_n == nbits));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         dout   <= 1'b0;
         done   <= 1'b0;
         sel_d  <= 1'b0;
         tx_sh  <= '0;
         rx_sh  <= '0;
         ecnt   <= '0;
         scnt   <= '0;
      end else begin
         done  <= 1'b0;
         sel_d <= slv_sel;
         if (go) begin
            active <= 1'b1;
            ecnt   <= '0;
            scnt   <= '0;
            rx_sh  <= '0;
            if (first_samp) begin
               dout  <= ld[LONG_LEN-1];
               tx_sh <= ld << 1;
            end else begin
               tx_sh <= ld;
            end
         end else if (!master && active && !slv_sel) begin
            active <= 1'b0;
         end else begin
            if (drv) begin
               dout  <= (echo && !master) ? rx_sh[0] : tx_sh[LONG_LEN-1];
               tx_sh <= tx_sh << 1;
            end
            if (smp) begin
               rx_sh <= {rx_sh[LONG_LEN-2:0], din};
               scnt  <= scnt_n;
            end
            if (drv | smp) ecnt <= ecnt_n;
            if (fin) begin
               active <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   assign rx_word = long_x ? rx_sh
                           : {{(LONG_LEN-SHORT_LEN){1'b0}}, rx_sh[SHORT_LEN-1:0]};
endmodule

// File: rtl/mwspi_regs.sv
module mwspi_regs
   import mwspi_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             re,
   input  logic [1:0]       addr,
   input  logic [DW-1:0]    wdata,
   input  logic             eng_active,
   input  logic             done,
   input  logic [DW-1:0]    rx_word,
   output cfg_t             cfg,
   output logic [DIV_W-1:0] div,
   output logic [DW-1:0]    tx_hold,
   output logic             go,
   output logic             busy,
   output logic             full,
   output logic             ovr,
   output logic [DW-1:0]    rdata,
   output logic             irq
);
   logic [DW-1:0] rbuf;
   logic          wr_data, rd_data, clr_ovr;

   assign busy    = eng_active | go;
   assign wr_data = we && (addr == A_DATA);
   assign rd_data = re && (addr == A_DATA);
   assign clr_ovr = we && (addr == A_STAT) && wdata[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg     <= '0;
         div     <= '0;
         tx_hold <= '0;
         go      <= 1'b0;
         rbuf    <= '0;
         full    <= 1'b0;
         ovr     <= 1'b0;
      end else begin
         go <= wr_data && !busy && cfg.master;
         if (wr_data && !busy)            tx_hold <= wdata;
         if (we && (addr == A_CTRL))      cfg     <= cfg_t'(wdata[$bits(cfg_t)-1:0]);
         if (we && (addr == A_DIV))       div     <= wdata[DIV_W-1:0];
         if (done) begin
            full <= 1'b1;
            if (full && !rd_data) ovr  <= 1'b1;
            else                  rbuf <= rx_word;
         end else begin
            if (rd_data) full <= 1'b0;
            if (clr_ovr) ovr  <= 1'b0;
         end
      end
   end

   always_comb begin
      case (addr)
         A_CTRL:  rdata = DW'(cfg);
         A_DATA:  rdata = rbuf;
         A_STAT:  rdata = DW'({ovr, full, busy});
         default: rdata = DW'(div);
      endcase
   end

   assign irq = (cfg.ie_busy & busy) | (cfg.ie_full & full) | (cfg.ie_ovr & ovr);
endmodule

// File: rtl/mwspi_ctrl.sv
module mwspi_ctrl
   import mwspi_pkg::*;
#(
   parameter int LONG_LEN    = 16,
   parameter int SHORT_LEN   = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic                reg_re,
   input  logic [1:0]          reg_addr,
   input  logic [LONG_LEN-1:0] reg_wdata,
   output logic [LONG_LEN-1:0] reg_rdata,
   output logic                irq,
   input  logic                sclk_i,
   output logic                sclk_o,
   output logic                sclk_oe,
   input  logic                lna_i,
   output logic                lna_o,
   output logic                lna_oe,
   input  logic                lnb_i,
   output logic                lnb_o,
   output logic                lnb_oe,
   input  logic                sel0_i,
   output logic                sel0_o,
   output logic                sel0_oe,
   output logic                sel1_o,
   output logic                sel1_oe
);
   initial begin
      assert (SHORT_LEN >= 2 && SHORT_LEN < LONG_LEN)
         else $error("SHORT_LEN must be 2 or more and below LONG_LEN");
      assert (LONG_LEN >= $bits(cfg_t))
         else $error("LONG_LEN too narrow for the configuration word");
      assert (DIV_W >= 1 && DIV_W <= LONG_LEN)
         else $error("DIV_W out of range");
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be 2 or more");
   end

   cfg_t                cfg;
   logic [DIV_W-1:0]    div;
   logic [LONG_LEN-1:0] tx_hold, rx_word;
   logic go, busy, full, ovr, eng_active, eng_done, dout;
   logic m_sclk, m_rise, m_fall;
   logic sclk_q, sclk_d, sel_q, slv_sel;
   logic rise, fall, din, act0, act1;

   mwspi_regs #(.DW(LONG_LEN), .DIV_W(DIV_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .re(reg_re), .addr(reg_addr),
      .wdata(reg_wdata), .eng_active(eng_active), .done(eng_done),
      .rx_word(rx_word), .cfg(cfg), .div(div), .tx_hold(tx_hold), .go(go),
      .busy(busy), .full(full), .ovr(ovr), .rdata(reg_rdata), .irq(irq)
   );

   mwspi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(cfg.master & eng_active),
      .idle_hi(cfg.idle_hi), .div(div), .sclk(m_sclk),
      .tick_rise(m_rise), .tick_fall(m_fall)
   );

   mwspi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(sclk_i), .q(sclk_q)
   );

   mwspi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
      .clk(clk), .rst_n(rst_n), .d(sel0_i), .q(sel_q)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_q;

   assign slv_sel = !cfg.master && (sel_q == cfg.sel_pol);
   assign rise    = cfg.master ? m_rise : (sclk_q & ~sclk_d);
   assign fall    = cfg.master ? m_fall : (~sclk_q & sclk_d);
   assign din     = cfg.master ? lna_i : lnb_i;

   mwspi_shifter #(.LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN)) u_shift (
      .clk(clk), .rst_n(rst_n), .master(cfg.master), .long_x(cfg.long_x),
      .alt(cfg.alt), .idle_hi(cfg.idle_hi), .echo(cfg.echo), .start(go),
      .slv_sel(slv_sel), .rise(rise), .fall(fall), .din(din),
      .tx_word(tx_hold), .active(eng_active), .dout(dout), .done(eng_done),
      .rx_word(rx_word)
   );

   assign act0    = cfg.master & busy & cfg.sel0_en;
   assign act1    = cfg.master & busy & cfg.sel1_en;
   assign sel0_o  = cfg.sel_pol ? act0 : ~act0;
   assign sel1_o  = cfg.sel_pol ? act1 : ~act1;
   assign sel0_oe = cfg.master;
   assign sel1_oe = cfg.master;
   assign sclk_o  = m_sclk;
   assign sclk_oe = cfg.master;
   assign lnb_o   = dout;
   assign lnb_oe  = cfg.master;
   assign lna_o   = dout;
   assign lna_oe  = slv_sel;
endmodule

// File: rtl/mwspi_ctrl_chk.sv
module mwspi_ctrl_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          master,
   input logic          alt,
   input logic          idle_hi,
   input logic          busy,
   input logic          sclk_o,
   input logic          lnb_o,
   input logic          lna_oe,
   input logic          full,
   input logic          ovr,
   input logic          done,
   input logic          we,
   input logic          re,
   input logic [1:0]    addr,
   input logic          wbit2,
   input logic [DW-1:0] tx_hold
);
   a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      master && !busy && $past(!busy) && $stable(idle_hi) && $stable(master)
      |-> sclk_o == idle_hi);

   a_r3_drive_edge: assert property (@(posedge clk) disable iff (!rst_n)
      master && busy && $past(busy) && $stable(master) && $stable(alt) && !$stable(lnb_o)
      |-> sclk_o == !alt);

   a_r7_slave_only_drive: assert property (@(posedge clk) disable iff (!rst_n)
      lna_oe |-> !master);

   a_r9_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
      full && re && addr == 2'd1 && !done |=> !full);

   a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovr && !(we && addr == 2'd2 && wbit2) |=> ovr);

   a_r11_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy && we && addr == 2'd1 |=> $stable(tx_hold));
endmodule

bind mwspi_ctrl mwspi_ctrl_chk #(.DW(LONG_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .master(cfg.master), .alt(cfg.alt),
   .idle_hi(cfg.idle_hi), .busy(busy), .sclk_o(sclk_o), .lnb_o(lnb_o),
   .lna_oe(lna_oe), .full(full), .ovr(ovr), .done(eng_done), .we(reg_we),
   .re(reg_re), .addr(reg_addr), .wbit2(reg_wdata[2]), .tx_hold(tx_hold)
);

// File: tb/mwspi_ctrl_bench.sv
module mwspi_ctrl_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0, reg_re = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic irq, sclk_o, sclk_oe, lna_o, lna_oe, lnb_o, lnb_oe;
   logic sel0_o, sel0_oe, sel1_o, sel1_oe;
   logic sclk_i = 1'b0, lnb_i = 1'b0, sel0_i = 1'b1;
   logic lna_i;

   int vecs = 0, errs = 0;
   bit finished = 0;

   always #4 clk = ~clk;
   assign lna_i = lnb_o;   // loopback for master transfers

   mwspi_ctrl u_mwspi_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
      .lna_i(lna_i), .lna_o(lna_o), .lna_oe(lna_oe), .lnb_i(lnb_i),
      .lnb_o(lnb_o), .lnb_oe(lnb_oe), .sel0_i(sel0_i), .sel0_o(sel0_o),
      .sel0_oe(sel0_oe), .sel1_o(sel1_o), .sel1_oe(sel1_oe)
   );

   // master-side line monitor
   bit mon_en = 0, mon_alt = 0;
   logic [15:0] cap = '0;
   int edges = 0, hmin = 0, hmax = 0, cyc = 0, last = 0;
   always @(negedge clk) cyc++;
   always @(posedge sclk_o) if (mon_en && mon_alt)  cap = {cap[14:0], lnb_o};
   always @(negedge sclk_o) if (mon_en && !mon_alt) cap = {cap[14:0], lnb_o};
   always @(sclk_o) if (mon_en) begin
      if (edges > 0) begin
         if (hmin == 0 || cyc - last < hmin) hmin = cyc - last;
         if (cyc - last > hmax) hmax = cyc - last;
      end
      last = cyc;
      edges++;
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [15:0] d);
      @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 0;
   endtask

   task automatic rd(logic [1:0] a, output logic [15:0] d);
      @(negedge clk); reg_re = 1; reg_addr = a; #1 d = reg_rdata;
      @(negedge clk); reg_re = 0;
   endtask

   task automatic wait_idle();
      logic [15:0] s;
      int guard = 0;
      do begin rd(2'd2, s); guard++; end while (s[0] && guard < 3000);
   endtask

   task automatic mon_start(bit a);
      mon_alt = a; cap = '0; edges = 0; hmin = 0; hmax = 0; mon_en = 1;
   endtask

   task automatic t_reset();
      logic [15:0] s;
      rd(2'd2, s);
      chk("R1", "status", s, 16'h0);
      chk("R1", "irq/sclk/sel0/sel1/lna_oe", {irq, sclk_o, sel0_o, sel1_o, lna_oe}, 5'b00110);
   endtask

   task automatic t_master_short();
      logic [15:0] s;
      wr(2'd3, 16'd1);
      wr(2'd0, 16'h0241);             // master, sel0_en, ie_full
      repeat (2) @(negedge clk);
      mon_start(0);
      wr(2'd1, 16'hAB3C);
      repeat (3) @(negedge clk);
      chk("R6", "sel0 active low / sel1 idle", {sel0_o, sel1_o}, 2'b01);
      wait_idle();
      mon_en = 0;
      chk("R2", "8-bit MSB-first on line", cap[7:0], 8'h3C);
      chk("R3", "normal mode capture bits", cap[15:8], 8'h00);
      chk("R4", "edge count 8-bit", edges, 16);
      chk("R5", "half period DIV=1", {hmin[7:0], hmax[7:0]}, {8'd2, 8'd2});
      chk("R4", "idle low after transfer", sclk_o, 1'b0);
      chk("R6", "sel0 released", sel0_o, 1'b1);
      chk("R12", "irq on full", irq, 1'b1);
      rd(2'd1, s);
      chk("R2", "8-bit receive word", s, 16'h003C);
      rd(2'd2, s);
      chk("R9", "full cleared by read", s, 16'h0);
      chk("R12", "irq drops", irq, 1'b0);
   endtask

   task automatic t_master_long_alt();
      logic [15:0] s;
      wr(2'd3, 16'd2);
      wr(2'd0, 16'h00AF);             // master,long,alt,idle_hi,pol high,sel1_en
      repeat (3) @(negedge clk);
      chk("R4", "idle high before start", sclk_o, 1'b1);
      mon_start(1);
      wr(2'd1, 16'hC3A5);
      repeat (3) @(negedge clk);
      chk("R6", "sel1 active high, sel0 off", {sel0_o, sel1_o}, 2'b01);
      wait_idle();
      mon_en = 0;
      chk("R3", "alternate mode 16-bit capture", cap, 16'hC3A5);
      chk("R4", "edge count 16-bit", edges, 32);
      chk("R5", "half period DIV=2", {hmin[7:0], hmax[7:0]}, {8'd3, 8'd3});
      chk("R4", "idle high after", sclk_o, 1'b1);
      rd(2'd1, s);
      chk("R2", "16-bit receive word", s, 16'hC3A5);
   endtask

   task automatic t_overrun();
      logic [15:0] s;
      wr(2'd3, 16'd0);
      wr(2'd0, 16'h0501);             // master, ie_busy, ie_ovr
      repeat (2) @(negedge clk);
      wr(2'd1, 16'h0011);
      @(negedge clk);
      chk("R12", "irq while busy", irq, 1'b1);
      wait_idle();
      chk("R12", "full masked", irq, 1'b0);
      wr(2'd1, 16'h0022);
      wait_idle();
      rd(2'd2, s);
      chk("R10", "overrun and full set", s, 16'h0006);
      chk("R12", "irq on overrun", irq, 1'b1);
      rd(2'd1, s);
      chk("R10", "buffer kept", s, 16'h0011);
      rd(2'd2, s);
      chk("R10", "overrun sticky after read", s, 16'h0004);
      wr(2'd2, 16'h0004);
      rd(2'd2, s);
      chk("R10", "overrun cleared by write 1", s, 16'h0000);
      chk("R12", "irq low", irq, 1'b0);
   endtask

   task automatic slv_xfer(bit altm, bit poke, logic [7:0] send, output logic [7:0] got);
      got = '0;
      @(negedge clk); sel0_i = 0;
      repeat (6) @(negedge clk);
      if (!altm) begin
         for (int i = 0; i < 8; i++) begin
            sclk_i = 1; lnb_i = send[7-i];
            repeat (8) @(negedge clk);
            got = {got[6:0], lna_o};
            sclk_i = 0;
            if (poke && i == 3) begin wr(2'd1, 16'h000F); repeat (6) @(negedge clk); end
            else repeat (8) @(negedge clk);
         end
      end else begin
         lnb_i = send[7];
         for (int i = 0; i < 8; i++) begin
            got = {got[6:0], lna_o};
            sclk_i = 1;
            repeat (8) @(negedge clk);
            sclk_i = 0;
            if (i < 7) lnb_i = send[6-i];
            repeat (8) @(negedge clk);
         end
      end
   endtask

   task automatic t_slave();
      logic [15:0] s;
      logic [7:0] got;
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h00A5);
      repeat (4) @(negedge clk);
      chk("R7", "no drive while deselected", {lna_oe, sclk_oe}, 2'b00);
      slv_xfer(0, 1, 8'h3C, got);
      chk("R7", "drives while selected", lna_oe, 1'b1);
      rd(2'd2, s);
      chk("R9", "slave done: full, not busy", s, 16'h0002);
      chk("R7", "slave sent word", got, 8'hA5);
      rd(2'd1, s);
      chk("R7", "slave received word", s, 16'h003C);
      @(negedge clk); sel0_i = 1;
      repeat (5) @(negedge clk);
      chk("R7", "released after deselect", lna_oe, 1'b0);
      slv_xfer(0, 0, 8'h5A, got);
      chk("R11", "held word unchanged by busy write", got, 8'hA5);
      @(negedge clk); sel0_i = 1;
      repeat (5) @(negedge clk);
      rd(2'd1, s);
      chk("R7", "second received word", s, 16'h005A);
   endtask

   task automatic t_echo();
      logic [15:0] s;
      logic [7:0] got;
      wr(2'd0, 16'h0014);             // slave, alt, echo
      slv_xfer(1, 0, 8'h96, got);
      chk("R8", "echoed bits", got[6:0], 7'h4B);
      @(negedge clk); sel0_i = 1;
      repeat (5) @(negedge clk);
      rd(2'd1, s);
      chk("R8", "echo receive word", s, 16'h0096);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      t_reset();
      t_master_short();
      t_master_long_alt();
      t_overrun();
      t_slave();
      t_echo();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         vecs++; errs++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end
endmodule